// File: doc/BRIEF.md
# Serial Bus Receive Acceptance Filter

This block sits in a serial-bus link layer and decides, header by header, whether an incoming packet should be taken in. It keeps the node's own address as a bus number and a node number. Software can write this address. After bus initialisation the PHY loads the node number. On a bus reset the bus number goes back to all ones. A valid flag says whether the address can be trusted. Asynchronous headers are accepted only when the flag is set and their destination matches the local address or one of the wildcard values.

Isochronous headers do not depend on the address. When the strict mode is on, the block tracks a time window that a cycle-start opens and a subaction gap closes. It rejects isochronous headers that fall outside that window. A receiver-enable control gates every acceptance. The decision is registered and appears one clock after the header strobe.

Top module: `bus_rx_filter`

## Requirements
- R1: After reset, `idReg` reads 0xFFFF0002 (bus field 0x3FF, node field 0x3F, version code 0x0002 in bits 15..0), `idValid` is 0 and `acceptValid` and `accept` are 0.
- R2: A `busReset` pulse sets the bus field (bits 31..22 of `idReg`) to 0x3FF, clears `idValid` and closes the isochronous window on the next clock, and it leaves the node field unchanged.
- R3: A `phyIdLoad` pulse loads `phyNodeId` into the node field (bits 21..16) and sets `idValid` on the next clock. A simultaneous `busReset` wins, and then the node field is unchanged and `idValid` is cleared.
- R4: A software write (`swIdWe`) loads bits 31..22 of `swIdData` into the bus field and bits 21..16 into the node field. Bits 15..0 have no effect and always read back as the version code. The write is ignored in a cycle that has `busReset` or `phyIdLoad`.
- R5: `swIdValidWe` writes `swIdValidVal` into `idValid`, unless `busReset` or `phyIdLoad` is high in the same cycle.
- R6: An asynchronous header (`hdrIsIso`=0) is accepted exactly when `rxEnable` and `idValid` are 1, `hdrDestBus` equals the bus field or is 0x3FF, and `hdrDestNode` equals the node field or is 63 (broadcast).
- R7: While `rxEnable` is 0, no header of either kind is accepted.
- R8: An isochronous header (`hdrIsIso`=1) with `rxEnable`=1 is accepted regardless of `idValid` and destination when `strictIso`=0. When `strictIso`=1 it is accepted only while the window is open.
- R9: The window opens on the clock after `cycleStart`. It closes on the clock after `subGap` or `busReset`, and either of these wins over a simultaneous `cycleStart`.
- R10: `acceptValid` is high exactly one clock after each `hdrValid` cycle, and `accept` is 0 whenever `acceptValid` is 0. The decision uses the address, flag and window as they stood in the `hdrValid` cycle, before that cycle's updates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busReset | input | 1 | Bus reset seen on the bus (pulse) |
| phyIdLoad | input | 1 | Self-identify complete, PHY node number present (pulse) |
| phyNodeId | input | 6 | Node number assigned by the PHY |
| swIdWe | input | 1 | Software write strobe for the address register |
| swIdData | input | 32 | Software write data, bus in 31..22, node in 21..16 |
| swIdValidWe | input | 1 | Software write strobe for the valid flag |
| swIdValidVal | input | 1 | Value written to the valid flag |
| rxEnable | input | 1 | Receiver enable |
| strictIso | input | 1 | Reject isochronous headers outside the window |
| cycleStart | input | 1 | Cycle-start received (pulse) |
| subGap | input | 1 | Subaction gap detected (pulse) |
| hdrValid | input | 1 | Header fields valid this cycle |
| hdrIsIso | input | 1 | Header is isochronous |
| hdrDestBus | input | 10 | Destination bus number |
| hdrDestNode | input | 6 | Destination node number |
| idReg | output | 32 | Address register read value |
| idValid | output | 1 | Local address valid flag |
| acceptValid | output | 1 | Decision present this cycle |
| accept | output | 1 | Header accepted |

## Verification
The bench builds the block with its default parameters: a 10-bit bus field, a 6-bit node field and a 16-bit version. With only 64 node numbers, random destinations hit the broadcast value and the local node on their own. Destinations are also biased toward the current local address and the 0x3FF wildcard, so the full match, wildcard and mismatch paths all occur often. The PHY, software and bus-reset strobes are rare, and some land in the same cycle, so the priority orderings and the reset-then-reload sequence come up within a few thousand cycles.

// File: rtl/bus_rx_filter_pkg.sv
package bus_rx_filter_pkg;
  // Address update strobes from control to datapath, already prioritised.
  typedef struct packed {
    logic revertBus;
    logic loadPhyNode;
    logic loadSw;
  } idStrobes_t;
endpackage

// File: rtl/rxf_ctrl.sv
module rxf_ctrl
  import bus_rx_filter_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       busReset,
  input  logic       phyIdLoad,
  input  logic       swIdWe,
  input  logic       swIdValidWe,
  input  logic       swIdValidVal,
  input  logic       cycleStart,
  input  logic       subGap,
  output idStrobes_t stb,
  output logic       idValid,
  output logic       isoWindow
);
  always_comb begin
    stb.revertBus   = busReset;
    stb.loadPhyNode = phyIdLoad && !busReset;
    stb.loadSw      = swIdWe && !busReset && !phyIdLoad;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idValid <= 1'b0;
    end else if (busReset) begin
      idValid <= 1'b0;
    end else if (phyIdLoad) begin
      idValid <= 1'b1;
    end else if (swIdValidWe) begin
      idValid <= swIdValidVal;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      isoWindow <= 1'b0;
    end else if (busReset || subGap) begin
      isoWindow <= 1'b0;
    end else if (cycleStart) begin
      isoWindow <= 1'b1;
    end
  end

  a_r2_valid_clear: assert property (@(posedge clk) disable iff (!rstN)
    busReset |=> !idValid);
  a_r3_valid_set: assert property (@(posedge clk) disable iff (!rstN)
    (phyIdLoad && !busReset) |=> idValid);
  a_r5_sw_valid: assert property (@(posedge clk) disable iff (!rstN)
    (swIdValidWe && !busReset && !phyIdLoad) |=> (idValid == $past(swIdValidVal)));
  a_r9_window_close: assert property (@(posedge clk) disable iff (!rstN)
    (subGap || busReset) |=> !isoWindow);
  a_r9_window_open: assert property (@(posedge clk) disable iff (!rstN)
    (cycleStart && !subGap && !busReset) |=> isoWindow);
endmodule

// File: rtl/rxf_dpath.sv
module rxf_dpath
  import bus_rx_filter_pkg::*;
#(
  parameter int BUS_W = 10,
  parameter int NODE_W = 6,
  parameter int VER_W = 16,
  parameter logic [VER_W-1:0] VERSION = 16'h0002,
  localparam int ID_W = BUS_W + NODE_W + VER_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  idStrobes_t        stb,
  input  logic [NODE_W-1:0] phyNodeId,
  input  logic [ID_W-1:0]   swIdData,
  input  logic              idValid,
  input  logic              isoWindow,
  input  logic              rxEnable,
  input  logic              strictIso,
  input  logic              hdrValid,
  input  logic              hdrIsIso,
  input  logic [BUS_W-1:0]  hdrDestBus,
  input  logic [NODE_W-1:0] hdrDestNode,
  output logic [ID_W-1:0]   idReg,
  output logic              acceptValid,
  output logic              accept
);
  localparam logic [BUS_W-1:0]  ANY_BUS   = '1;
  localparam logic [NODE_W-1:0] BCAST     = '1;
  localparam int                NODE_LSB  = VER_W;
  localparam int                BUS_LSB   = VER_W + NODE_W;

  logic [BUS_W-1:0]  busId;
  logic [NODE_W-1:0] nodeId;
  logic busMatch, nodeMatch, asyncOk, isoOk, decision;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busId  <= ANY_BUS;
      nodeId <= BCAST;
    end else begin
      if (stb.revertBus) busId <= ANY_BUS;
      else if (stb.loadSw) busId <= swIdData[BUS_LSB +: BUS_W];
      if (stb.loadPhyNode) nodeId <= phyNodeId;
      else if (stb.loadSw) nodeId <= swIdData[NODE_LSB +: NODE_W];
    end
  end

  assign idReg = {busId, nodeId, VERSION};

  always_comb begin
    busMatch  = (hdrDestBus == ANY_BUS) || (hdrDestBus == busId);
    nodeMatch = (hdrDestNode == BCAST) || (hdrDestNode == nodeId);
    asyncOk   = idValid && busMatch && nodeMatch;
    isoOk     = !strictIso || isoWindow;
    decision  = rxEnable && (hdrIsIso ? isoOk : asyncOk);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acceptValid <= 1'b0;
      accept      <= 1'b0;
    end else begin
      acceptValid <= hdrValid;
      accept      <= hdrValid && decision;
    end
  end

  a_r2_bus_revert: assert property (@(posedge clk) disable iff (!rstN)
    stb.revertBus |=> (idReg[BUS_LSB +: BUS_W] == ANY_BUS));
  a_r3_node_load: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadPhyNode |=> (idReg[NODE_LSB +: NODE_W] == $past(phyNodeId)));
  a_r7_disabled: assert property (@(posedge clk) disable iff (!rstN)
    (hdrValid && !rxEnable) |=> !accept);
  a_r8_strict_outside: assert property (@(posedge clk) disable iff (!rstN)
    (hdrValid && hdrIsIso && strictIso && !isoWindow) |=> !accept);
  a_r10_strobe_follow: assert property (@(posedge clk) disable iff (!rstN)
    hdrValid |=> acceptValid);
  a_r10_no_strobe: assert property (@(posedge clk) disable iff (!rstN)
    !hdrValid |=> !acceptValid);
  a_r10_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !acceptValid |-> !accept);
endmodule

// File: rtl/bus_rx_filter.sv
module bus_rx_filter
  import bus_rx_filter_pkg::*;
#(
  parameter int BUS_W = 10,
  parameter int NODE_W = 6,
  parameter int VER_W = 16,
  parameter logic [VER_W-1:0] VERSION = 16'h0002,
  localparam int ID_W = BUS_W + NODE_W + VER_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busReset,
  input  logic              phyIdLoad,
  input  logic [NODE_W-1:0] phyNodeId,
  input  logic              swIdWe,
  input  logic [ID_W-1:0]   swIdData,
  input  logic              swIdValidWe,
  input  logic              swIdValidVal,
  input  logic              rxEnable,
  input  logic              strictIso,
  input  logic              cycleStart,
  input  logic              subGap,
  input  logic              hdrValid,
  input  logic              hdrIsIso,
  input  logic [BUS_W-1:0]  hdrDestBus,
  input  logic [NODE_W-1:0] hdrDestNode,
  output logic [ID_W-1:0]   idReg,
  output logic              idValid,
  output logic              acceptValid,
  output logic              accept
);
  idStrobes_t stb;
  logic       isoWindow;

  rxf_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .busReset(busReset), .phyIdLoad(phyIdLoad),
    .swIdWe(swIdWe), .swIdValidWe(swIdValidWe), .swIdValidVal(swIdValidVal),
    .cycleStart(cycleStart), .subGap(subGap), .stb(stb),
    .idValid(idValid), .isoWindow(isoWindow)
  );

  rxf_dpath #(
    .BUS_W(BUS_W), .NODE_W(NODE_W), .VER_W(VER_W), .VERSION(VERSION)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .phyNodeId(phyNodeId),
    .swIdData(swIdData), .idValid(idValid), .isoWindow(isoWindow),
    .rxEnable(rxEnable), .strictIso(strictIso), .hdrValid(hdrValid),
    .hdrIsIso(hdrIsIso), .hdrDestBus(hdrDestBus), .hdrDestNode(hdrDestNode),
    .idReg(idReg), .acceptValid(acceptValid), .accept(accept)
  );
endmodule

// File: tb/sim_bus_rx_filter.sv
module sim_bus_rx_filter;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busReset = 0, phyIdLoad = 0, swIdWe = 0, swIdValidWe = 0, swIdValidVal = 0;
  logic rxEnable = 0, strictIso = 0, cycleStart = 0, subGap = 0;
  logic hdrValid = 0, hdrIsIso = 0;
  logic [5:0]  phyNodeId = 0, hdrDestNode = 0;
  logic [9:0]  hdrDestBus = 0;
  logic [31:0] swIdData = 0;
  logic [31:0] idReg;
  logic idValid, acceptValid, accept;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // reference model state
  logic [9:0] mBus = 10'h3FF;
  logic [5:0] mNode = 6'h3F;
  logic mValid = 0, mWin = 0;
  logic eAccV = 0, eAcc = 0;

  always #10 clk = ~clk;

  bus_rx_filter u0 (
    .clk(clk), .rstN(rstN), .busReset(busReset), .phyIdLoad(phyIdLoad),
    .phyNodeId(phyNodeId), .swIdWe(swIdWe), .swIdData(swIdData),
    .swIdValidWe(swIdValidWe), .swIdValidVal(swIdValidVal),
    .rxEnable(rxEnable), .strictIso(strictIso), .cycleStart(cycleStart),
    .subGap(subGap), .hdrValid(hdrValid), .hdrIsIso(hdrIsIso),
    .hdrDestBus(hdrDestBus), .hdrDestNode(hdrDestNode), .idReg(idReg),
    .idValid(idValid), .acceptValid(acceptValid), .accept(accept)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic expDecision();
    logic busOk, nodeOk;
    busOk  = (hdrDestBus == 10'h3FF) || (hdrDestBus == mBus);
    nodeOk = (hdrDestNode == 6'h3F) || (hdrDestNode == mNode);
    if (!rxEnable) return 1'b0;
    if (hdrIsIso) return !strictIso || mWin;
    return mValid && busOk && nodeOk;
  endfunction

  function automatic string decTag();
    if (!rxEnable) return "R7";
    if (hdrIsIso) return "R8";
    return "R6";
  endfunction

  // One clock: model update, then compare all outputs at the falling edge.
  task automatic step();
    string tag;
    tag   = hdrValid ? decTag() : "R10";
    eAccV = hdrValid;
    eAcc  = hdrValid && expDecision();
    if (busReset) begin
      mBus = 10'h3FF; mValid = 0;
    end else if (phyIdLoad) begin
      mNode = phyNodeId; mValid = 1;
    end else begin
      if (swIdWe) begin mBus = swIdData[31:22]; mNode = swIdData[21:16]; end
      if (swIdValidWe) mValid = swIdValidVal;
    end
    if (busReset || subGap) mWin = 0;
    else if (cycleStart) mWin = 1;
    @(posedge clk);
    @(negedge clk);
    chk("R10", {31'd0, acceptValid}, {31'd0, eAccV});
    chk(tag, {31'd0, accept}, {31'd0, eAcc});
    chk("R2/R3/R4", idReg, {mBus, mNode, 16'h0002});
    chk("R5", {31'd0, idValid}, {31'd0, mValid});
  endtask

  task automatic idle();
    busReset = 0; phyIdLoad = 0; swIdWe = 0; swIdValidWe = 0;
    cycleStart = 0; subGap = 0; hdrValid = 0;
  endtask

  task automatic hdr(logic iso, logic [9:0] b, logic [5:0] n);
    hdrValid = 1; hdrIsIso = iso; hdrDestBus = b; hdrDestNode = n;
  endtask

  initial begin
    #4000000;
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1", idReg, 32'hFFFF0002);
    chk("R1", {31'd0, idValid}, 32'd0);
    chk("R1", {30'd0, acceptValid, accept}, 32'd0);
    rstN = 1;
    rxEnable = 1;
    // R6: before the flag is set an exact broadcast is rejected
    hdr(0, 10'h3FF, 6'h3F); step(); idle();
    // R4: software write, low bits ignored
    swIdWe = 1; swIdData = 32'h1234_ABCD; step(); idle();
    chk("R4", idReg, {32'h1234_ABCD & 32'hFFFF0000} | 32'h0002);
    // R3 and R2 together: bus reset wins
    busReset = 1; phyIdLoad = 1; phyNodeId = 6'd5; step(); idle();
    chk("R3", {26'd0, idReg[21:16]}, {26'd0, 6'h34});
    // R3: PHY load sets node and flag
    phyIdLoad = 1; phyNodeId = 6'd9; step(); idle();
    // R6: match, wildcard bus, broadcast node, mismatch
    hdr(0, 10'h3FF, 6'd9); step(); idle();
    hdr(0, 10'h3FF, 6'h3F); step(); idle();
    hdr(0, 10'h001, 6'd9); step(); idle();
    // R5: software clears the flag, R10: decision uses the old flag
    swIdValidWe = 1; swIdValidVal = 0; hdr(0, 10'h3FF, 6'd9); step(); idle();
    hdr(0, 10'h3FF, 6'd9); step(); idle();
    // R7
    rxEnable = 0; hdr(1, 0, 0); step(); idle(); rxEnable = 1;
    // R8/R9 strict window
    strictIso = 1; hdr(1, 0, 0); step(); idle();
    cycleStart = 1; step(); idle();
    hdr(1, 0, 0); step(); idle();
    cycleStart = 1; subGap = 1; step(); idle();
    hdr(1, 0, 0); step(); idle();
    strictIso = 0; hdr(1, 0, 0); step(); idle();
    // random phase
    for (int i = 0; i < 4000; i++) begin
      int r;
      idle();
      busReset    = ($urandom % 40) == 0;
      phyIdLoad   = ($urandom % 20) == 0;
      phyNodeId   = 6'($urandom);
      swIdWe      = ($urandom % 30) == 0;
      swIdData    = $urandom;
      swIdValidWe = ($urandom % 30) == 0;
      swIdValidVal = 1'($urandom);
      cycleStart  = ($urandom % 8) == 0;
      subGap      = ($urandom % 8) == 0;
      if (($urandom % 50) == 0) rxEnable = ~rxEnable;
      if (($urandom % 30) == 0) strictIso = ~strictIso;
      hdrValid = 1'($urandom);
      hdrIsIso = ($urandom % 4) == 0;
      r = int'($urandom % 6);
      hdrDestBus = (r < 2) ? mBus : (r == 2) ? 10'h3FF : 10'($urandom);
      r = int'($urandom % 6);
      hdrDestNode = (r < 2) ? mNode : (r == 2) ? 6'h3F : 6'($urandom);
      step();
    end
    idle();
    step();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule